// File: doc/BRIEF.md
# Bus Access Wait-State Generator

This block measures how long each processor bus access lasts, counted in master clocks. One base unit of processor time equals 12 master clocks: a 24.576 MHz master clock divided by 12 gives the 2.048 MHz processor base. Two 2-bit divider fields come from the control register.

- The internal field covers idle cycles, the I/O register window and the boot ROM while it is mapped.
- The external field covers every other access, which goes to RAM through the sound DSP.

A requester pulses `acc_start` with the access kind and the address. The block then holds `acc_busy` for the whole length of the access. It raises `acc_done` for one clock in the last cycle.

The settings are meant to divide by 2, 4, 8 and 16. The two larger settings do not divide evenly into 12 master clocks, so they give odd lengths: setting 2 lasts 10 base units and setting 3 lasts only 2. The block reproduces these lengths exactly, so a processor model built on it shows the same slowdown and instability as the real hardware. Instruction execution is handled elsewhere.

Top module: `wait_state_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `acc_busy` and `acc_done` are low.
- R2: An accepted access keeps `acc_busy` high for exactly U*12 clocks, starting in the cycle after the accepting edge. U is 2, 4, 10 or 2 for divider setting 0, 1, 2 or 3. `acc_done` is high only in the last of those clocks.
- R3: A read or write whose address is outside the I/O window and outside the mapped boot ROM uses `ext_sel`, which holds control register bits 5:4.
- R4: A read or write to addresses 00F0h to 00FFh uses `int_sel`, which holds control register bits 7:6.
- R5: A read or write to FFC0h to FFFFh uses `int_sel` when `rom_map` is 1, and `ext_sel` when `rom_map` is 0.
- R6: An idle cycle uses `int_sel` whatever the address.
- R7: The kind, address, `rom_map` and both divider fields are sampled only at the accepting edge. Changing them during an access does not change its length.
- R8: A start pulse while `acc_busy` is high and `acc_done` is low is ignored. The running access ends on time, and no new access follows it.
- R9: A start in the cycle where `acc_done` is high is accepted. The new access has `acc_busy` high in the next cycle, with no gap.
- R10: `acc_kind` encodes 00 as idle, 01 as read and 10 as write. The value 11 is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_start | input | 1 | Request pulse that starts an access |
| acc_kind | input | 2 | Access kind: 00 idle, 01 read, 10 write, 11 read |
| acc_addr | input | 16 | Address of the access |
| rom_map | input | 1 | High when the boot ROM overlays FFC0h to FFFFh |
| ext_sel | input | 2 | External divider field (control register bits 5:4) |
| int_sel | input | 2 | Internal divider field (control register bits 7:6) |
| acc_busy | output | 1 | High while an access is in progress |
| acc_done | output | 1 | High for one clock, in the last cycle of an access |

## Verification
The only state is the remaining-cycle counter, the busy flag and the length captured at acceptance. Any fault in them shows at the ports within one access: `acc_done` arrives on the wrong clock, or `acc_busy` stays high or drops too early. A wrong region decode gives a length of the wrong domain, for example 48 clocks instead of 120. That difference is visible by the end of that same access. Comparing both outputs on every clock against a behavioural model pins any such divergence to the exact cycle.

// File: rtl/wsg_pkg.sv
// Package: shared types and the divider-setting to base-unit mapping.
// Assumes the divider fields are 2 bits wide.
package wsg_pkg;

    typedef enum logic [1:0] {
        KIND_IDLE  = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_READX = 2'b11
    } acc_kind_t;

    localparam int MAX_UNITS = 10;

    // Base units taken by one access for a given divider setting.
    function automatic int units_for(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 4;
            2'd2:    return 10;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/wsg_region_decode.sv
// Region decode: chooses the internal or the external divider domain for
// an access. Assumes the I/O window is aligned to its own size.
module wsg_region_decode #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] IO_BASE  = 16'h00F0,
    parameter int          IO_SIZE  = 16,
    parameter logic [15:0] ROM_BASE = 16'hFFC0
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_map,
    output logic              use_int
);
    import wsg_pkg::*;

    localparam logic [ADDR_W-1:0] IO_MASK  = ~ADDR_W'(IO_SIZE - 1);
    localparam logic [ADDR_W-1:0] IO_B     = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] ROM_B    = ADDR_W'(ROM_BASE);

    logic io_hit;
    logic rom_hit;
    logic is_idle;

    // Combinational region match and domain selection.
    always_comb begin
        io_hit  = ((addr & IO_MASK) == IO_B);
        rom_hit = rom_map && (addr >= ROM_B);
        is_idle = (acc_kind_t'(kind) == KIND_IDLE);
        use_int = is_idle || io_hit || rom_hit;
    end

endmodule

// File: rtl/wsg_len_select.sv
// Length select: converts the chosen divider field into an access length
// in master clocks. Assumes MCLK_PER_UNIT * MAX_UNITS fits in LEN_W bits.
module wsg_len_select #(
    parameter int MCLK_PER_UNIT = 12,
    parameter int LEN_W         = 7
) (
    input  logic             use_int,
    input  logic [1:0]       ext_sel,
    input  logic [1:0]       int_sel,
    output logic [LEN_W-1:0] len
);
    import wsg_pkg::*;

    logic [1:0] sel;

    // Pick the field for the domain and scale its unit count.
    always_comb begin
        sel = use_int ? int_sel : ext_sel;
        len = LEN_W'(units_for(sel) * MCLK_PER_UNIT);
    end

endmodule

// File: rtl/wsg_cycle_counter.sv
// Cycle counter: a down-counter loaded when an access is accepted. Done is
// flagged when it reaches zero. Assumes len is at least 1.
module wsg_cycle_counter #(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done,
    output logic             accept
);
    logic             busy_q;
    logic [LEN_W-1:0] cnt_q;

    // Done in the final cycle; a start is taken when idle or in that cycle.
    always_comb begin
        done   = busy_q && (cnt_q == '0);
        accept = start && (!busy_q || done);
        busy   = busy_q;
    end

    // Load on accept, count down while busy, release after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= len - LEN_W'(1);
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - LEN_W'(1);
        end
    end

    // R2, R8: mid-access the counter steps down by one, start or not.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));

    // R2: a finished access with no new start leaves the counter idle.
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy_q);

endmodule

// File: rtl/wait_state_gen.sv
// Top: bus access wait-state generator. Decodes the access domain, picks
// the divider length and times the access. Assumes one access at a time.
module wait_state_gen #(
    parameter int MCLK_PER_UNIT = 12,
    parameter int ADDR_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              rom_map,
    input  logic [1:0]        ext_sel,
    input  logic [1:0]        int_sel,
    output logic              acc_busy,
    output logic              acc_done
);
    import wsg_pkg::*;

    localparam int LEN_W = $clog2(MAX_UNITS * MCLK_PER_UNIT + 1);

    logic             use_int;
    logic [LEN_W-1:0] len;
    logic             accept;

    wsg_region_decode #(.ADDR_W(ADDR_W)) u_decode (
        .kind    (acc_kind),
        .addr    (acc_addr),
        .rom_map (rom_map),
        .use_int (use_int)
    );

    wsg_len_select #(.MCLK_PER_UNIT(MCLK_PER_UNIT), .LEN_W(LEN_W)) u_len (
        .use_int (use_int),
        .ext_sel (ext_sel),
        .int_sel (int_sel),
        .len     (len)
    );

    wsg_cycle_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (acc_start),
        .len    (len),
        .busy   (acc_busy),
        .done   (acc_done),
        .accept (accept)
    );

    // R1: reset clears the access in progress.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !acc_busy);

    // R2: done appears only inside an access.
    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> acc_busy);

    // R9: a start in the done cycle continues without a gap.
    assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && acc_start) |=> (acc_busy && !acc_done));

    // R2: an access taken from idle is busy and not done in its first cycle.
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !acc_busy) |=> (acc_busy && !acc_done));

endmodule

// File: tb/wait_state_gen_tb.sv
module wait_state_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0;
    logic [1:0]  acc_kind = 2'b01;
    logic [15:0] acc_addr = 16'h0000;
    logic        rom_map = 1'b0;
    logic [1:0]  ext_sel = 2'd0;
    logic [1:0]  int_sel = 2'd0;
    logic        acc_busy;
    logic        acc_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    bit model_busy = 0;
    int model_rem  = 0;

    always #5 clk = ~clk;

    wait_state_gen u_dut (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .rom_map(rom_map), .ext_sel(ext_sel),
        .int_sel(int_sel), .acc_busy(acc_busy), .acc_done(acc_done)
    );

    function automatic int units_of(input logic [1:0] s);
        if (s == 2'd2) return 10;
        if (s == 2'd1) return 4;
        return 2;
    endfunction

    function automatic int exp_len(input logic [1:0] k, input logic [15:0] a,
                                   input logic rm, input logic [1:0] e,
                                   input logic [1:0] i);
        bit internal;
        internal = (k == 2'b00) || (a >= 16'h00F0 && a <= 16'h00FF) ||
                   (rm && a >= 16'hFFC0);
        return 12 * units_of(internal ? i : e);
    endfunction

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_busy = 0;
            model_rem  = 0;
        end else if (acc_start && (!model_busy || model_rem == 1)) begin
            model_busy = 1;
            model_rem  = exp_len(acc_kind, acc_addr, rom_map, ext_sel, int_sel);
        end else if (model_busy) begin
            if (model_rem == 1) model_busy = 0;
            else model_rem = model_rem - 1;
        end
    end

    // Per-cycle comparison on the falling edge (R2 timing).
    always @(negedge clk) begin
        bit exp_done;
        cyc++;
        exp_done = model_busy && (model_rem == 1);
        n_cmp++;
        if (acc_busy !== model_busy || acc_done !== exp_done) begin
            n_bad++;
            $display("FAIL R2 cycle %0d: busy/done=%b%b expected %b%b",
                     cyc, acc_busy, acc_done, model_busy, exp_done);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Start one access and return its measured length in clocks.
    task automatic measure(input logic [1:0] k, input logic [15:0] a,
                           input logic rm, input logic [1:0] e,
                           input logic [1:0] i, input int mid_change,
                           input int mid_start, output int len);
        acc_kind = k; acc_addr = a; rom_map = rm; ext_sel = e; int_sel = i;
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        len = 1;
        while (!acc_done && len < 400) begin
            if (len == 3 && mid_change != 0) begin
                acc_kind = 2'b01; acc_addr = 16'h1234; rom_map = ~rm;
                ext_sel = ~e; int_sel = ~i;
            end
            acc_start = (len == 5 && mid_start != 0);
            @(negedge clk);
            len++;
        end
        acc_start = 1'b0;
    endtask

    initial begin
        int l;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", acc_busy, 0);
        check("R1 done in reset", acc_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", acc_busy, 0);

        for (int s = 0; s < 4; s++) begin
            measure(2'b01, 16'h0200, 0, 2'(s), 2'(3 - s), 0, 0, l);
            check("R2 R3 ext length", l, exp_len(2'b01, 16'h0200, 0, 2'(s), 2'(3 - s)));
            @(negedge clk);
        end
        for (int s = 0; s < 4; s++) begin
            measure(2'b10, 16'h00F0 + 16'(s * 5), 0, 2'(3 - s), 2'(s), 0, 0, l);
            check("R2 R4 io length", l, 12 * units_of(2'(s)));
            @(negedge clk);
        end
        measure(2'b01, 16'h00EF, 0, 2'd1, 2'd2, 0, 0, l);
        check("R4 below io window", l, 48);
        @(negedge clk);
        measure(2'b01, 16'hFFC0, 1, 2'd0, 2'd2, 0, 0, l);
        check("R5 rom mapped", l, 120);
        @(negedge clk);
        measure(2'b01, 16'hFFFF, 0, 2'd0, 2'd2, 0, 0, l);
        check("R5 rom unmapped", l, 24);
        @(negedge clk);
        measure(2'b01, 16'hFFBF, 1, 2'd1, 2'd2, 0, 0, l);
        check("R5 below rom", l, 48);
        @(negedge clk);
        measure(2'b00, 16'h0400, 0, 2'd0, 2'd2, 0, 0, l);
        check("R6 idle internal", l, 120);
        @(negedge clk);
        measure(2'b11, 16'h0400, 0, 2'd1, 2'd0, 0, 0, l);
        check("R10 kind 11 as read", l, 48);
        @(negedge clk);
        measure(2'b01, 16'h0300, 0, 2'd1, 2'd0, 1, 0, l);
        check("R7 mid-access change", l, 48);
        @(negedge clk);
        measure(2'b01, 16'h0300, 0, 2'd2, 2'd0, 0, 1, l);
        check("R8 start while busy", l, 120);
        @(negedge clk);
        check("R8 no follow-on access", acc_busy, 0);

        // R9: start raised in the done cycle continues without a gap.
        acc_kind = 2'b01; acc_addr = 16'h0100; ext_sel = 2'd0; rom_map = 0;
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        while (!acc_done) @(negedge clk);
        ext_sel = 2'd1;
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        check("R9 back-to-back busy", acc_busy, 1);
        l = 1;
        while (!acc_done && l < 400) begin @(negedge clk); l++; end
        check("R9 second length", l, 48);
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule